// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block sits at the home node of a small distributed shared-memory machine with two to four nodes. For each of a handful of memory blocks it holds a directory entry: a three-valued sharing state (no cached copy, read-only copies, one writable copy) and a bit-vector with one bit per node that names the nodes holding a copy. It also holds the home copy of each block's data.

Nodes send it three kinds of request: a read miss, a write miss, or a write-back of a dirty block. It handles one request at a time. If other caches must give up or hand back their copies, it first sends invalidate, fetch or fetch-and-invalidate messages to those nodes, one per cycle. It waits until each of those nodes has acknowledged. It then updates the entry and sends the requester a data reply. A fetch acknowledgement carries the owner's data, which is written into the home memory before the reply goes out. Caches and the network are outside the block. Every message leaves on a single output channel.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block has no cached copy, an empty sharer vector and zero data; `busy` and `msg_valid` are low.
- R2: A read miss to a block with no copy, or with read-only copies, sends no message to other nodes. The reply carries the home data, the requester joins the sharer vector, and the block becomes read-only shared.
- R3: A write miss to a block with no copy replies with the home data and makes the requester the only holder of a writable copy.
- R4: A read miss to a block held writable by another node sends one fetch (kind 2) to the owner. The owner's acknowledgement data is written to the home memory and returned in the reply. The block becomes shared by both owner and requester.
- R5: A write miss to a shared block sends an invalidate (kind 1) to every sharer except the requester, in ascending node order. After all of them are acknowledged it replies and leaves the requester as sole writable owner.
- R6: A write miss to a block held writable by another node sends one fetch-and-invalidate (kind 3) to the owner. The acknowledgement data goes to memory and to the reply, and ownership moves to the requester.
- R7: A write-back (req_type 2) from the writable owner stores its data, empties the sharer vector and returns the block to no-copy, with no message and no busy cycle. A write-back from any other node, or to a block not held writable, is ignored.
- R8: A request (req_type 0 read, 1 write) is taken at a clock edge when `busy` is low. `busy` is high from the next cycle through the reply cycle and low right after it. Requests presented while `busy` is high are dropped, and messages appear only while busy.
- R9: A read or write miss from the node that already holds the block writable replies with the home data. It sends no other message and leaves the entry unchanged.
- R10: A message of kind 0 is the data reply, addressed to the requester for the requested block. An acknowledgement is accepted only from a node that has a message outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_node | input | NODE_W | Requesting node |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| busy | output | 1 | A request is in progress; new requests are dropped |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_node | output | NODE_W | Destination node |
| msg_blk | output | BLK_W | Block the message refers to |
| msg_data | output | DATA_W | Reply data (zero for other kinds) |
| ack_valid | input | 1 | Acknowledgement from a node |
| ack_node | input | NODE_W | Acknowledging node |
| ack_data | input | DATA_W | Owner data returned with a fetch acknowledgement |

## Verification
The bench goes after the transitions that leave a holder out of step with the entry. It checks that the requester is left out of its own invalidation list; a design that got this wrong would send a spurious invalidate and wait for an acknowledgement that the requester never sends. It checks that fetched owner data, not stale home data, appears in the reply; a wrong design would return the value written before the owner's modification. Ignored write-backs from non-owners are probed by a later read that must still fetch from the true owner. Requests poked in while busy must not start a second transaction, and a design that latched them would raise `busy` again after the reply.

// File: rtl/dir_pkg.sv
package dir_pkg;

   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_EXC = 2'd2
   } dir_state_e;

   typedef enum logic [1:0] {
      RQ_READ  = 2'd0,
      RQ_WRITE = 2'd1,
      RQ_WBACK = 2'd2
   } req_kind_e;

   typedef enum logic [1:0] {
      MK_DATA      = 2'd0,
      MK_INV       = 2'd1,
      MK_FETCH     = 2'd2,
      MK_FETCH_INV = 2'd3
   } msg_kind_e;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_SEND  = 2'd1,
      FS_WAIT  = 2'd2,
      FS_REPLY = 2'd3
   } fsm_e;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
   import dir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int BLOCKS = 8,
   parameter int BLK_W  = $clog2(BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] rd_blk,
   output dir_state_e       rd_state,
   output logic [NODES-1:0] rd_shr,
   input  logic             wr_en,
   input  logic [BLK_W-1:0] wr_blk,
   input  dir_state_e       wr_state,
   input  logic [NODES-1:0] wr_shr
);

   dir_state_e       st_arr  [BLOCKS];
   logic [NODES-1:0] shr_arr [BLOCKS];

   // one register pair per block
   for (genvar g = 0; g < BLOCKS; g++) begin : g_ent
      dir_state_e       st_q;
      logic [NODES-1:0] shr_q;
      logic             hit;

      assign hit = wr_en && (wr_blk == BLK_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= DS_UNC;
            shr_q <= '0;
         end else if (hit) begin
            st_q  <= wr_state;
            shr_q <= wr_shr;
         end
      end

      assign st_arr[g]  = st_q;
      assign shr_arr[g] = shr_q;
   end

   assign rd_state = st_arr[rd_blk];
   assign rd_shr   = shr_arr[rd_blk];

endmodule

// File: rtl/dir_data_mem.sv
module dir_data_mem #(
   parameter int DATA_W         = 16,
   parameter int BLOCKS         = 8,
   parameter int BLK_W          = $clog2(BLOCKS),
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BLK_W-1:0]  wr_blk,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BLK_W-1:0]  rd_blk,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [BLOCKS];

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < BLOCKS; i++) mem_q[i] <= '0;
         end else if (wr_en) begin
            mem_q[wr_blk] <= wr_data;
         end
      end
   end else begin : g_noclr
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (wr_en) mem_q[wr_blk] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_blk];

endmodule

// File: rtl/node_pick.sv
module node_pick #(
   parameter int NODES  = 4,
   parameter int NODE_W = $clog2(NODES)
) (
   input  logic [NODES-1:0]  mask,
   output logic              any,
   output logic [NODE_W-1:0] idx
);

   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NODES - 1; i >= 0; i--) begin
         if (mask[i]) begin
            any = 1'b1;
            idx = NODE_W'(i);
         end
      end
   end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int BLOCKS = 8,
   parameter int DATA_W = 16,
   parameter int NODE_W = $clog2(NODES),
   parameter int BLK_W  = $clog2(BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_type,
   input  logic [NODE_W-1:0] req_node,
   input  logic [BLK_W-1:0]  req_blk,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              msg_valid,
   output logic [1:0]        msg_kind,
   output logic [NODE_W-1:0] msg_node,
   output logic [BLK_W-1:0]  msg_blk,
   output logic [DATA_W-1:0] msg_data,
   input  logic              ack_valid,
   input  logic [NODE_W-1:0] ack_node,
   input  logic [DATA_W-1:0] ack_data
);

   localparam logic [NODES-1:0] BIT0 = NODES'(1);

   if (NODES < 2 || NODES > 4) begin : g_bad_nodes
      $error("dir_home_ctrl: NODES must be 2..4");
   end
   if (BLOCKS < 2) begin : g_bad_blocks
      $error("dir_home_ctrl: BLOCKS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dir_home_ctrl: DATA_W must be positive");
   end

   // transaction registers
   fsm_e              fsm_q, fsm_d;
   logic [1:0]        op_q, op_d;
   logic [NODE_W-1:0] node_q, node_d;
   logic [BLK_W-1:0]  blk_q, blk_d;
   logic [NODES-1:0]  pend_q, pend_d;
   logic [NODES-1:0]  sent_q, sent_d;
   msg_kind_e         kind_q, kind_d;

   // directory and memory ports
   logic [BLK_W-1:0]  rd_blk;
   dir_state_e        rd_state;
   logic [NODES-1:0]  rd_shr;
   logic              dir_we;
   logic [BLK_W-1:0]  dir_wblk;
   dir_state_e        dir_wst;
   logic [NODES-1:0]  dir_wshr;
   logic              mem_we;
   logic [BLK_W-1:0]  mem_wblk;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rd;

   // decode helpers
   logic              accept;
   logic [NODES-1:0]  req_bit, own_bit, ack_bit, pick_bit;
   logic              held_by_req, held_by_own;
   logic              ack_take;
   logic              pick_any;
   logic [NODE_W-1:0] pick_idx;

   dir_entry_store #(
      .NODES (NODES),
      .BLOCKS(BLOCKS),
      .BLK_W (BLK_W)
   ) u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_blk  (rd_blk),
      .rd_state(rd_state),
      .rd_shr  (rd_shr),
      .wr_en   (dir_we),
      .wr_blk  (dir_wblk),
      .wr_state(dir_wst),
      .wr_shr  (dir_wshr)
   );

   dir_data_mem #(
      .DATA_W        (DATA_W),
      .BLOCKS        (BLOCKS),
      .BLK_W         (BLK_W),
      .CLEAR_ON_RESET(1'b1)
   ) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mem_we),
      .wr_blk (mem_wblk),
      .wr_data(mem_wdata),
      .rd_blk (blk_q),
      .rd_data(mem_rd)
   );

   node_pick #(
      .NODES (NODES),
      .NODE_W(NODE_W)
   ) u_pick (
      .mask(pend_q),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign busy        = (fsm_q != FS_IDLE);
   assign accept      = (fsm_q == FS_IDLE) && req_valid;
   assign rd_blk      = (fsm_q == FS_IDLE) ? req_blk : blk_q;
   assign req_bit     = BIT0 << req_node;
   assign own_bit     = BIT0 << node_q;
   assign ack_bit     = BIT0 << ack_node;
   assign pick_bit    = BIT0 << pick_idx;
   assign held_by_req = (rd_state == DS_EXC) && (rd_shr == req_bit);
   assign held_by_own = (rd_state == DS_EXC) && (rd_shr == own_bit);
   assign ack_take    = ack_valid && ((sent_q & ack_bit) != '0);

   always_comb begin
      fsm_d     = fsm_q;
      op_d      = op_q;
      node_d    = node_q;
      blk_d     = blk_q;
      pend_d    = pend_q;
      kind_d    = kind_q;
      sent_d    = ack_take ? (sent_q & ~ack_bit) : sent_q;
      dir_we    = 1'b0;
      dir_wblk  = blk_q;
      dir_wst   = DS_UNC;
      dir_wshr  = '0;
      mem_we    = 1'b0;
      mem_wblk  = blk_q;
      mem_wdata = ack_data;

      // returned owner data lands in the home copy
      if (ack_take && (kind_q != MK_INV)) begin
         mem_we = 1'b1;
      end

      unique case (fsm_q)
         FS_IDLE: begin
            if (accept) begin
               op_d   = req_type;
               node_d = req_node;
               blk_d  = req_blk;
               pend_d = '0;
               case (req_type)
                  RQ_READ: begin
                     kind_d = MK_FETCH;
                     fsm_d  = FS_SEND;
                     if (rd_state == DS_EXC && !held_by_req) pend_d = rd_shr;
                  end
                  RQ_WRITE: begin
                     fsm_d = FS_SEND;
                     if (rd_state == DS_SHR) begin
                        kind_d = MK_INV;
                        pend_d = rd_shr & ~req_bit;
                     end else if (rd_state == DS_EXC && !held_by_req) begin
                        kind_d = MK_FETCH_INV;
                        pend_d = rd_shr;
                     end
                  end
                  RQ_WBACK: begin
                     if (held_by_req) begin
                        mem_we    = 1'b1;
                        mem_wblk  = req_blk;
                        mem_wdata = req_data;
                        dir_we    = 1'b1;
                        dir_wblk  = req_blk;
                        dir_wst   = DS_UNC;
                        dir_wshr  = '0;
                     end
                  end
                  default: ;
               endcase
            end
         end
         FS_SEND: begin
            if (pick_any) begin
               pend_d = pend_q & ~pick_bit;
               sent_d = sent_d | pick_bit;
            end else begin
               fsm_d = FS_WAIT;
            end
         end
         FS_WAIT: begin
            if (sent_q == '0) fsm_d = FS_REPLY;
         end
         FS_REPLY: begin
            fsm_d = FS_IDLE;
            if (op_q == RQ_READ) begin
               if (!held_by_own) begin
                  dir_we   = 1'b1;
                  dir_wst  = DS_SHR;
                  dir_wshr = rd_shr | own_bit;
               end
            end else begin
               dir_we   = 1'b1;
               dir_wst  = DS_EXC;
               dir_wshr = own_bit;
            end
         end
         default: fsm_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q  <= FS_IDLE;
         op_q   <= RQ_READ;
         node_q <= '0;
         blk_q  <= '0;
         pend_q <= '0;
         sent_q <= '0;
         kind_q <= MK_DATA;
      end else begin
         fsm_q  <= fsm_d;
         op_q   <= op_d;
         node_q <= node_d;
         blk_q  <= blk_d;
         pend_q <= pend_d;
         sent_q <= sent_d;
         kind_q <= kind_d;
      end
   end

   always_comb begin
      msg_valid = 1'b0;
      msg_kind  = MK_DATA;
      msg_node  = pick_idx;
      msg_blk   = blk_q;
      msg_data  = '0;
      if (fsm_q == FS_SEND && pick_any) begin
         msg_valid = 1'b1;
         msg_kind  = kind_q;
      end else if (fsm_q == FS_REPLY) begin
         msg_valid = 1'b1;
         msg_kind  = MK_DATA;
         msg_node  = node_q;
         msg_data  = mem_rd;
      end
   end

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int NODES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             msg_valid,
   input logic [1:0]       msg_kind,
   input logic [1:0]       rd_state,
   input logic [NODES-1:0] rd_shr
);

   // writable block has exactly one holder
   assert_excl_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_state == 2'd2) |-> ($countones(rd_shr) == 1));

   // no-copy block has an empty sharer vector
   assert_unc_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_state == 2'd0) |-> (rd_shr == '0));

   // shared block always names at least one holder
   assert_shared_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_state == 2'd1) |-> (rd_shr != '0));

   // no spare encoding in the directory
   assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_state != 2'd3);

   // traffic only inside a transaction
   assert_msg_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> busy);

   // the data reply closes the transaction
   assert_reply_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == 2'd0) |=> !busy);

endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .msg_valid(msg_valid),
   .msg_kind (msg_kind),
   .rd_state (rd_state),
   .rd_shr   (rd_shr)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;

   localparam int NODES  = 4;
   localparam int BLOCKS = 8;
   localparam int DW     = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_type = '0;
   logic [1:0]    req_node = '0;
   logic [2:0]    req_blk = '0;
   logic [DW-1:0] req_data = '0;
   logic          busy;
   logic          msg_valid;
   logic [1:0]    msg_kind;
   logic [1:0]    msg_node;
   logic [2:0]    msg_blk;
   logic [DW-1:0] msg_data;
   logic          ack_valid = 1'b0;
   logic [1:0]    ack_node = '0;
   logic [DW-1:0] ack_data = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference directory: 0 none, 1 shared, 2 writable
   int          m_st  [BLOCKS];
   int          m_shr [BLOCKS];
   logic [DW-1:0] m_mem [BLOCKS];
   int          serial = 1;

   always #4 clk = ~clk;

   dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_type(req_type), .req_node(req_node),
      .req_blk(req_blk), .req_data(req_data),
      .busy(busy), .msg_valid(msg_valid), .msg_kind(msg_kind),
      .msg_node(msg_node), .msg_blk(msg_blk), .msg_data(msg_data),
      .ack_valid(ack_valid), .ack_node(ack_node), .ack_data(ack_data)
   );

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle_check(string tag);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         chk(busy == 1'b0, tag, "busy after transaction", int'(busy), 0);
         chk(msg_valid == 1'b0, tag, "stray message", int'(msg_valid), 0);
      end
   endtask

   // write-back: no message, no busy cycle
   task automatic wback(int nd, int bk, logic [DW-1:0] wd, string tag);
      @(negedge clk);
      req_valid = 1'b1; req_type = 2'd2; req_node = 2'(nd);
      req_blk = 3'(bk); req_data = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b0, tag, "busy after write-back", int'(busy), 0);
      chk(msg_valid == 1'b0, tag, "message after write-back", int'(msg_valid), 0);
      if (m_st[bk] == 2 && m_shr[bk] == (1 << nd)) begin
         m_st[bk] = 0; m_shr[bk] = 0; m_mem[bk] = wd;
      end
   endtask

   // read (rt 0) or write (rt 1) miss with the bench acting as all caches
   task automatic miss(int rt, int nd, int bk, bit poke, string tag);
      int exp_nodes[$];
      int exp_kind;
      int ackq_n[$];
      logic [DW-1:0] ackq_d[$];
      bit fetched;
      logic [DW-1:0] fdata;
      logic [DW-1:0] exp_data;
      bit got_reply;
      int me;
      me = 1 << nd;
      fetched = 1'b0;
      fdata = '0;
      exp_kind = 0;
      got_reply = 1'b0;
      if (rt == 0) begin
         if (m_st[bk] == 2 && m_shr[bk] != me) begin
            exp_kind = 2;
            for (int i = 0; i < NODES; i++) if (m_shr[bk][i]) exp_nodes.push_back(i);
         end
      end else begin
         if (m_st[bk] == 1) begin
            exp_kind = 1;
            for (int i = 0; i < NODES; i++)
               if (m_shr[bk][i] && i != nd) exp_nodes.push_back(i);
         end else if (m_st[bk] == 2 && m_shr[bk] != me) begin
            exp_kind = 3;
            for (int i = 0; i < NODES; i++) if (m_shr[bk][i]) exp_nodes.push_back(i);
         end
      end
      @(negedge clk);
      req_valid = 1'b1; req_type = 2'(rt); req_node = 2'(nd); req_blk = 3'(bk);
      for (int it = 0; it < 100 && !got_reply; it++) begin
         @(negedge clk);
         req_valid = 1'b0;
         chk(busy == 1'b1, "R8", "busy during transaction", int'(busy), 1);
         if (poke && it == 1) begin
            req_valid = 1'b1; req_type = 2'd1; req_node = 2'((nd + 1) % NODES);
            req_blk = 3'(bk);
         end
         ack_valid = 1'b0;
         if (ackq_n.size() > 0) begin
            ack_valid = 1'b1;
            ack_node = 2'(ackq_n.pop_front());
            ack_data = ackq_d.pop_front();
         end
         if (msg_valid) begin
            if (msg_kind != 2'd0) begin
               if (exp_nodes.size() == 0) begin
                  chk(1'b0, tag, "unexpected message node", int'(msg_node), -1);
               end else begin
                  int en;
                  en = exp_nodes.pop_front();
                  chk(int'(msg_node) == en, tag, "target node", int'(msg_node), en);
                  chk(int'(msg_kind) == exp_kind, tag, "target kind", int'(msg_kind), exp_kind);
                  chk(int'(msg_blk) == bk, tag, "target block", int'(msg_blk), bk);
               end
               ackq_n.push_back(int'(msg_node));
               if (msg_kind != 2'd1) begin
                  fetched = 1'b1;
                  fdata = DW'(16'hC000 + serial * 16 + int'(msg_node));
                  serial++;
                  ackq_d.push_back(fdata);
               end else begin
                  ackq_d.push_back('0);
               end
            end else begin
               got_reply = 1'b1;
               exp_data = fetched ? fdata : m_mem[bk];
               chk(int'(msg_node) == nd, "R10", "reply node", int'(msg_node), nd);
               chk(int'(msg_blk) == bk, "R10", "reply block", int'(msg_blk), bk);
               chk(msg_data == exp_data, tag, "reply data", int'(msg_data), int'(exp_data));
            end
         end
      end
      ack_valid = 1'b0;
      req_valid = 1'b0;
      chk(got_reply, tag, "reply seen", int'(got_reply), 1);
      chk(exp_nodes.size() == 0, tag, "missing target messages", exp_nodes.size(), 0);
      if (fetched) m_mem[bk] = fdata;
      if (rt == 0) begin
         if (!(m_st[bk] == 2 && m_shr[bk] == me)) begin
            m_st[bk] = 1; m_shr[bk] = m_shr[bk] | me;
         end
      end else begin
         m_st[bk] = 2; m_shr[bk] = me;
      end
      idle_check(poke ? "R8" : tag);
   endtask

   initial begin
      for (int b = 0; b < BLOCKS; b++) begin
         m_st[b] = 0; m_shr[b] = 0; m_mem[b] = '0;
      end
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      chk(msg_valid == 1'b0, "R1", "message in reset", int'(msg_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

      miss(0, 0, 2, 1'b0, "R1");   // zero data from a fresh block
      miss(0, 1, 2, 1'b0, "R2");   // second reader joins
      miss(1, 2, 2, 1'b0, "R5");   // invalidates 0 and 1
      miss(0, 3, 2, 1'b1, "R4");   // fetch from 2, poke while busy
      miss(1, 0, 5, 1'b0, "R3");   // no copy -> writable
      miss(1, 1, 5, 1'b0, "R6");   // ownership moves 0 -> 1
      miss(0, 1, 5, 1'b0, "R9");   // owner reads its own block
      miss(1, 1, 5, 1'b0, "R9");   // owner writes its own block
      wback(2, 5, 16'h1234, "R7"); // non-owner write-back ignored
      miss(0, 3, 5, 1'b0, "R7");   // must still fetch from node 1
      wback(1, 5, 16'h2222, "R7"); // block shared now: ignored
      miss(1, 3, 5, 1'b0, "R5");   // invalidates node 1 only
      wback(3, 5, 16'hBEEF, "R7"); // owner write-back accepted
      miss(0, 0, 5, 1'b0, "R7");   // home data is the written value
      miss(1, 2, 2, 1'b0, "R5");   // requester excluded from its own list
      miss(0, 0, 7, 1'b0, "R2");
      miss(0, 1, 7, 1'b0, "R2");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule